// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the combinational data-processing unit of a 32-bit RISC core. It receives a 4-bit operation code, a first operand taken from a register, and a second operand already shaped by the barrel shifter outside this block. It returns the operation result, a flag that says whether the destination register is written, and the next values of the four condition flags: negative, zero, carry and overflow. The flag register lives outside the block. Its current contents enter on four input pins, and the incoming carry is the current carry flag.

One shared adder serves all eight arithmetic and compare operations. Each subtraction is formed by inverting one operand and choosing a carry-in. Eight bitwise, test and move operations go through a separate logic unit. The compare and test forms compute their value only to produce flags and never request a register write. When the set-flags input is low, all four flag outputs repeat the flag inputs.

Top module: `dp_alu`

## Requirements
- R1: Arithmetic opcodes produce these results modulo 2^32. 0100 gives rn+op2. 0101 gives rn+op2+C. 0010 gives rn-op2. 0110 gives rn-op2+C-1. 0011 gives op2-rn. 0111 gives op2-rn+C-1. Compare 1010 yields rn-op2 and compare 1011 yields rn+op2 on the result port.
- R2: Bitwise and move opcodes produce these results. 0000 gives rn&op2. 0001 gives rn^op2. 1100 gives rn|op2. 1110 gives rn&~op2. 1101 gives op2. 1111 gives ~op2. Test 1000 yields rn&op2 and test 1001 yields rn^op2 on the result port.
- R3: reg_write is 0 for the four opcodes 1000, 1001, 1010 and 1011, and 1 for every other opcode.
- R4: With set_flags at 1, flag_n_out equals result bit 31, and flag_z_out is 1 exactly when all 32 result bits are zero.
- R5: With set_flags at 1 on an arithmetic or compare opcode, flag_c_out is the unsigned carry out of an addition. For subtraction forms it is 1 when no borrow occurs.
- R6: With set_flags at 1 on an arithmetic or compare opcode, flag_v_out is 1 exactly when the signed result does not fit in 32 bits.
- R7: With set_flags at 1 on a bitwise, test or move opcode, flag_c_out equals shift_carry and flag_v_out equals flag_v_in.
- R8: With set_flags at 0, each flag output equals its flag input, whatever the opcode.
- R9: The carry-using opcodes 0101, 0110 and 0111 take their carry from flag_c_in. The other arithmetic opcodes ignore it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode | input | 4 | Operation code |
| rn | input | 32 | First operand |
| op2 | input | 32 | Second operand from the shifter |
| shift_carry | input | 1 | Carry out of the shifter |
| set_flags | input | 1 | Allow flag update |
| flag_n_in | input | 1 | Current negative flag |
| flag_z_in | input | 1 | Current zero flag |
| flag_c_in | input | 1 | Current carry flag, also the carry-in |
| flag_v_in | input | 1 | Current overflow flag |
| result | output | 32 | Operation result |
| reg_write | output | 1 | Destination register write request |
| flag_n_out | output | 1 | Next negative flag |
| flag_z_out | output | 1 | Next zero flag |
| flag_c_out | output | 1 | Next carry flag |
| flag_v_out | output | 1 | Next overflow flag |

## Verification
The block holds no state, so an error in any internal control signal shows at the ports as soon as the inputs settle. A wrong operand inversion or carry-in selection gives a wrong result, or a flipped carry or overflow, on the first vector that uses that opcode. A wrong flag source only shows when the operands make the two candidate flag values differ. For that reason the random vectors randomize the shifter carry and the incoming flags independently of the operands. The directed cases cover the sign-boundary and equal-operand inputs, where carry and overflow change value.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

   typedef enum logic [3:0] {
      OP_AND = 4'b0000,
      OP_EOR = 4'b0001,
      OP_SUB = 4'b0010,
      OP_RSB = 4'b0011,
      OP_ADD = 4'b0100,
      OP_ADC = 4'b0101,
      OP_SBC = 4'b0110,
      OP_RSC = 4'b0111,
      OP_TST = 4'b1000,
      OP_TEQ = 4'b1001,
      OP_CMP = 4'b1010,
      OP_CMN = 4'b1011,
      OP_ORR = 4'b1100,
      OP_MOV = 4'b1101,
      OP_BIC = 4'b1110,
      OP_MVN = 4'b1111
   } dp_op_e;

   typedef enum logic [1:0] {
      CIN_ZERO,
      CIN_ONE,
      CIN_FLAG
   } cin_sel_e;

   typedef enum logic [2:0] {
      LF_AND,
      LF_XOR,
      LF_OR,
      LF_ANDN,
      LF_PASS,
      LF_NOT
   } logic_fn_e;

   typedef struct packed {
      logic      is_arith;
      logic      wr_en;
      logic      inv_a;
      logic      inv_b;
      cin_sel_e  cin_sel;
      logic_fn_e lfn;
   } dp_ctrl_t;

endpackage

// File: rtl/dp_decode.sv
module dp_decode
   import dp_alu_pkg::*;
(
   input  logic [3:0] opcode,
   output dp_ctrl_t   ctrl
);

   always_comb begin
      ctrl          = '0;
      ctrl.wr_en    = (opcode[3:2] != 2'b10);
      ctrl.cin_sel  = CIN_ZERO;
      ctrl.lfn      = LF_PASS;
      unique case (dp_op_e'(opcode))
         OP_ADD, OP_CMN: begin
            ctrl.is_arith = 1'b1;
         end
         OP_ADC: begin
            ctrl.is_arith = 1'b1;
            ctrl.cin_sel  = CIN_FLAG;
         end
         OP_SUB, OP_CMP: begin
            ctrl.is_arith = 1'b1;
            ctrl.inv_b    = 1'b1;
            ctrl.cin_sel  = CIN_ONE;
         end
         OP_SBC: begin
            ctrl.is_arith = 1'b1;
            ctrl.inv_b    = 1'b1;
            ctrl.cin_sel  = CIN_FLAG;
         end
         OP_RSB: begin
            ctrl.is_arith = 1'b1;
            ctrl.inv_a    = 1'b1;
            ctrl.cin_sel  = CIN_ONE;
         end
         OP_RSC: begin
            ctrl.is_arith = 1'b1;
            ctrl.inv_a    = 1'b1;
            ctrl.cin_sel  = CIN_FLAG;
         end
         OP_AND, OP_TST: ctrl.lfn = LF_AND;
         OP_EOR, OP_TEQ: ctrl.lfn = LF_XOR;
         OP_ORR:         ctrl.lfn = LF_OR;
         OP_BIC:         ctrl.lfn = LF_ANDN;
         OP_MOV:         ctrl.lfn = LF_PASS;
         OP_MVN:         ctrl.lfn = LF_NOT;
         default:        ctrl.lfn = LF_PASS;
      endcase
   end

endmodule

// File: rtl/dp_adder.sv
module dp_adder #(
   parameter int WIDTH = 32,
   parameter int STYLE = 1
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cout,
   output logic             ovf
);

   localparam int MSB = WIDTH - 1;

   if (STYLE == 0) begin : g_behav
      assign {cout, sum} = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
   end else begin : g_ripple
      logic [WIDTH:0] cy;
      assign cy[0] = cin;
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         assign sum[i]  = a[i] ^ b[i] ^ cy[i];
         assign cy[i+1] = (a[i] & b[i]) | (cy[i] & (a[i] ^ b[i]));
      end
      assign cout = cy[WIDTH];

      always_comb begin
         AST_RIPPLE_SUM: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}))
            else $error("ripple adder disagrees with reference sum"); // R5
      end
   end

   assign ovf = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);

endmodule

// File: rtl/dp_logic.sv
module dp_logic
   import dp_alu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic_fn_e        fn,
   output logic [WIDTH-1:0] y
);

   always_comb begin
      unique case (fn)
         LF_AND:  y = a & b;
         LF_XOR:  y = a ^ b;
         LF_OR:   y = a | b;
         LF_ANDN: y = a & ~b;
         LF_NOT:  y = ~b;
         default: y = b;
      endcase
   end

endmodule

// File: rtl/dp_flags.sv
module dp_flags #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] res,
   input  logic             set_flags,
   input  logic             is_arith,
   input  logic             add_cout,
   input  logic             add_ovf,
   input  logic             shift_carry,
   input  logic [3:0]       nzcv_in,
   output logic [3:0]       nzcv_out
);

   localparam int MSB = WIDTH - 1;

   logic n_new, z_new, c_new, v_new;

   always_comb begin
      n_new = res[MSB];
      z_new = (res == '0);
      c_new = is_arith ? add_cout : shift_carry;
      v_new = is_arith ? add_ovf  : nzcv_in[0];
      nzcv_out = set_flags ? {n_new, z_new, c_new, v_new} : nzcv_in;
   end

endmodule

// File: rtl/dp_alu.sv
module dp_alu
   import dp_alu_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int ADDER_STYLE = 1
) (
   input  logic [3:0]        opcode,
   input  logic [DATA_W-1:0] rn,
   input  logic [DATA_W-1:0] op2,
   input  logic              shift_carry,
   input  logic              set_flags,
   input  logic              flag_n_in,
   input  logic              flag_z_in,
   input  logic              flag_c_in,
   input  logic              flag_v_in,
   output logic [DATA_W-1:0] result,
   output logic              reg_write,
   output logic              flag_n_out,
   output logic              flag_z_out,
   output logic              flag_c_out,
   output logic              flag_v_out
);

   localparam int MSB = DATA_W - 1;

   if (DATA_W < 2) begin : g_bad_width
      $error("dp_alu: DATA_W must be at least 2");
   end
   if (ADDER_STYLE != 0 && ADDER_STYLE != 1) begin : g_bad_style
      $error("dp_alu: ADDER_STYLE must be 0 or 1");
   end

   dp_ctrl_t          ctrl;
   logic [DATA_W-1:0] add_a, add_b, add_sum, log_y;
   logic              add_cin, add_cout, add_ovf;
   logic [3:0]        nzcv_next;

   dp_decode i_decode (
      .opcode (opcode),
      .ctrl   (ctrl)
   );

   always_comb begin
      add_a = ctrl.inv_a ? ~rn  : rn;
      add_b = ctrl.inv_b ? ~op2 : op2;
      unique case (ctrl.cin_sel)
         CIN_ONE:  add_cin = 1'b1;
         CIN_FLAG: add_cin = flag_c_in;
         default:  add_cin = 1'b0;
      endcase
   end

   dp_adder #(.WIDTH(DATA_W), .STYLE(ADDER_STYLE)) i_adder (
      .a    (add_a),
      .b    (add_b),
      .cin  (add_cin),
      .sum  (add_sum),
      .cout (add_cout),
      .ovf  (add_ovf)
   );

   dp_logic #(.WIDTH(DATA_W)) i_logic (
      .a  (rn),
      .b  (op2),
      .fn (ctrl.lfn),
      .y  (log_y)
   );

   assign result    = ctrl.is_arith ? add_sum : log_y;
   assign reg_write = ctrl.wr_en;

   dp_flags #(.WIDTH(DATA_W)) i_flags (
      .res         (result),
      .set_flags   (set_flags),
      .is_arith    (ctrl.is_arith),
      .add_cout    (add_cout),
      .add_ovf     (add_ovf),
      .shift_carry (shift_carry),
      .nzcv_in     ({flag_n_in, flag_z_in, flag_c_in, flag_v_in}),
      .nzcv_out    (nzcv_next)
   );

   assign {flag_n_out, flag_z_out, flag_c_out, flag_v_out} = nzcv_next;

   always_comb begin
      AST_COMPARE_NO_WRITE: assert (opcode[3:2] != 2'b10 || !reg_write)
         else $error("compare/test opcode requested a register write"); // R3
      AST_FLAGS_HOLD: assert (set_flags || ({flag_n_out, flag_z_out, flag_c_out, flag_v_out}
                                            == {flag_n_in, flag_z_in, flag_c_in, flag_v_in}))
         else $error("flags changed with set_flags low"); // R8
      AST_NEG_MSB: assert (!set_flags || flag_n_out == result[MSB])
         else $error("negative flag differs from result sign"); // R4
      AST_ZERO_RESULT: assert (!set_flags || flag_z_out == (result == '0))
         else $error("zero flag differs from result"); // R4
      AST_LOGIC_KEEP_V: assert (!set_flags || ctrl.is_arith || flag_v_out == flag_v_in)
         else $error("bitwise op touched overflow flag"); // R7
      AST_LOGIC_SHIFT_C: assert (!set_flags || ctrl.is_arith || flag_c_out == shift_carry)
         else $error("bitwise op carry not from shifter"); // R7
   end

endmodule

// File: tb/test_dp_alu.sv
module test_dp_alu;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic [3:0]  opcode = '0;
   logic [31:0] rn = '0, op2 = '0;
   logic        shift_carry = 0, set_flags = 0;
   logic        n_in = 0, z_in = 0, c_in = 0, v_in = 0;
   logic [31:0] result;
   logic        reg_write, n_out, z_out, c_out, v_out;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dp_alu i_dp_alu (
      .opcode (opcode), .rn (rn), .op2 (op2), .shift_carry (shift_carry),
      .set_flags (set_flags), .flag_n_in (n_in), .flag_z_in (z_in),
      .flag_c_in (c_in), .flag_v_in (v_in), .result (result),
      .reg_write (reg_write), .flag_n_out (n_out), .flag_z_out (z_out),
      .flag_c_out (c_out), .flag_v_out (v_out)
   );

   // returns {result, wr, n, z, c, v}
   function automatic logic [36:0] ref_model(
      input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
      input logic sh, input logic s, input logic ni, input logic zi,
      input logic ci, input logic vi);
      logic signed [34:0] sa, sb, sx;
      logic [33:0] ua, ub;
      logic [31:0] r;
      logic arith, c, v, wr;
      sa = $signed({{3{a[31]}}, a});
      sb = $signed({{3{b[31]}}, b});
      ua = {2'b00, a};
      ub = {2'b00, b};
      arith = 1'b1;
      sx = '0;
      c = 1'b0;
      r = '0;
      case (op)
         4'b0100, 4'b1011: begin sx = sa + sb; c = (ua + ub) >= 34'h1_0000_0000; end
         4'b0101: begin sx = sa + sb + ci; c = (ua + ub + ci) >= 34'h1_0000_0000; end
         4'b0010, 4'b1010: begin sx = sa - sb; c = ua >= ub; end
         4'b0110: begin sx = sa - sb - !ci; c = ua >= ub + !ci; end
         4'b0011: begin sx = sb - sa; c = ub >= ua; end
         4'b0111: begin sx = sb - sa - !ci; c = ub >= ua + !ci; end
         default: arith = 1'b0;
      endcase
      if (arith) begin
         r = sx[31:0];
         v = (sx[34:31] != 4'b0000) && (sx[34:31] != 4'b1111);
      end else begin
         case (op)
            4'b0000, 4'b1000: r = a & b;
            4'b0001, 4'b1001: r = a ^ b;
            4'b1100: r = a | b;
            4'b1110: r = a & ~b;
            4'b1101: r = b;
            default: r = ~b;
         endcase
         c = sh;
         v = vi;
      end
      wr = (op[3:2] != 2'b10);
      if (s) ref_model = {r, wr, r[31], (r == 32'd0), c, v};
      else   ref_model = {r, wr, ni, zi, ci, vi};
   endfunction

   task automatic check_bit(input string tag, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s op=%b rn=%h op2=%h actual=%b expected=%b",
                  tag, what, opcode, rn, op2, act, exp);
      end
   endtask

   task automatic run_vec(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                          input logic sh, input logic s, input logic ni, input logic zi,
                          input logic ci, input logic vi, input string rtag);
      logic [36:0] e;
      bit arith;
      string ctag, vtag, restag;
      @(negedge clk);
      opcode = op; rn = a; op2 = b; shift_carry = sh; set_flags = s;
      n_in = ni; z_in = zi; c_in = ci; v_in = vi;
      @(posedge clk);
      #1;
      e = ref_model(op, a, b, sh, s, ni, zi, ci, vi);
      arith = (op[3:2] == 2'b01) || (op[3:1] == 3'b001) || (op[3:1] == 3'b101);
      restag = (rtag != "") ? rtag : (arith ? "R1" : "R2");
      ctag = !s ? "R8" : (arith ? "R5" : "R7");
      vtag = !s ? "R8" : (arith ? "R6" : "R7");
      checks++;
      if (result !== e[36:5]) begin
         errors++;
         $display("FAIL %s result op=%b rn=%h op2=%h cin=%b actual=%h expected=%h",
                  restag, op, a, b, ci, result, e[36:5]);
      end
      check_bit("R3", "reg_write", reg_write, e[4]);
      check_bit(s ? "R4" : "R8", "N", n_out, e[3]);
      check_bit(s ? "R4" : "R8", "Z", z_out, e[2]);
      check_bit(ctag, "C", c_out, e[1]);
      check_bit(vtag, "V", v_out, e[0]);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      // reset state: all inputs zero, AND of zeros, flags hold
      #1;
      checks++;
      if (result !== 32'd0 || reg_write !== 1'b1 || {n_out, z_out, c_out, v_out} !== 4'b0000) begin
         errors++;
         $display("FAIL R8 initial outputs actual=%h/%b/%b expected=0/1/0000",
                  result, reg_write, {n_out, z_out, c_out, v_out});
      end
      // R6 signed overflow at the sign boundary
      run_vec(4'b0100, 32'h7FFF_FFFF, 32'h1, 0, 1, 0, 0, 0, 0, "");
      run_vec(4'b0010, 32'h8000_0000, 32'h1, 0, 1, 0, 0, 0, 0, "");
      // R5 carry out of add, no-borrow on equal subtract, borrow on 0-1
      run_vec(4'b0100, 32'hFFFF_FFFF, 32'h1, 0, 1, 0, 0, 0, 0, "");
      run_vec(4'b1010, 32'h1234_5678, 32'h1234_5678, 0, 1, 0, 0, 0, 0, "");
      run_vec(4'b0010, 32'h0, 32'h1, 1, 1, 0, 0, 1, 1, "");
      // R9 carry-in used by ADC, SBC, RSC; ignored by ADD/SUB/RSB
      run_vec(4'b0101, 32'h10, 32'h20, 0, 1, 0, 0, 1, 0, "R9");
      run_vec(4'b0101, 32'hFFFF_FFFF, 32'h0, 0, 1, 0, 0, 1, 0, "R9");
      run_vec(4'b0110, 32'h10, 32'h10, 0, 1, 0, 0, 0, 0, "R9");
      run_vec(4'b0110, 32'h10, 32'h10, 0, 1, 0, 0, 1, 0, "R9");
      run_vec(4'b0111, 32'h5, 32'h3, 0, 1, 0, 0, 0, 0, "R9");
      run_vec(4'b0111, 32'h5, 32'h3, 0, 1, 0, 0, 1, 0, "R9");
      run_vec(4'b0100, 32'h5, 32'h3, 0, 1, 0, 0, 1, 0, "R9");
      run_vec(4'b0011, 32'h5, 32'h3, 0, 1, 0, 0, 1, 0, "R9");
      // R2 / R7 logic ops: carry from shifter, V kept
      run_vec(4'b1111, 32'h0, 32'h0, 1, 1, 0, 0, 0, 1, "");
      run_vec(4'b1110, 32'hFF00_FF00, 32'hF0F0_F0F0, 0, 1, 1, 1, 1, 0, "");
      run_vec(4'b1000, 32'hAAAA_AAAA, 32'h5555_5555, 1, 1, 0, 0, 0, 1, "");
      run_vec(4'b1001, 32'hCAFE_0000, 32'hCAFE_0000, 0, 1, 0, 0, 1, 1, "");
      run_vec(4'b1101, 32'h0, 32'h8000_0000, 1, 1, 0, 1, 0, 0, "");
      // R8 flags hold with set_flags low on an overflowing add
      run_vec(4'b0100, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 0, 0, 0, 1, 0, 0, "");
      run_vec(4'b1011, 32'hFFFF_FFFF, 32'h1, 1, 0, 1, 0, 1, 0, "");
      // R3 every opcode once
      for (int k = 0; k < 16; k++)
         run_vec(k[3:0], 32'h0F0F_1234, 32'h00F0_4321, 1, 1, 0, 0, 1, 0, "");
      // constrained random: all opcodes, with edge values mixed in
      for (int k = 0; k < 3000; k++) begin
         logic [31:0] a, b;
         logic [3:0] f;
         a = $urandom;
         b = $urandom;
         case ($urandom % 8)
            0: a = 32'h8000_0000;
            1: b = 32'h7FFF_FFFF;
            2: b = a;
            3: a = 32'h0;
            default: ;
         endcase
         f = 4'($urandom);
         run_vec(4'($urandom), a, b, f[0], ($urandom % 4) != 0, f[1], f[2], f[3],
                 1'($urandom), "");
      end
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule